// File: doc/BRIEF.md
# Segment LCD Command Decoder and Display RAM Writer

This block sits behind a two-wire serial receiver in a four-common segment LCD driver. The receiver hands over one byte at a time. Each byte carries a tag that says whether it is a command or display data. Commands update a small set of control registers: clock source, frame rate, drive inversion, drive-strength mode, display enable, blink rate and an all-pixel override. Display data bytes are written into a 20-word by 4-bit display RAM. One word holds one segment, and each of its bits holds one common line.

Each data byte fills two RAM words. The upper nibble goes to the current pointer and the lower nibble to the following word. The pointer then moves on by two and wraps from the last segment back to zero. A display scanner reads the control registers directly from the outputs and fetches RAM words through a combinational read port. Power-on reset is an input that clears everything, including the RAM. The software reset command restores the register defaults and the pointer but leaves the RAM contents in place.

Top module: `segram_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises, the outputs hold: `clk_ext`=0, `frame_sel`=0 (80 Hz), `frame_inv`=0 (line inversion), `drive_mode`=2'b10 (normal), `disp_en`=0, `blink_sel`=0 (off), `pix_all_on`=0, `pix_all_off`=0 and `wr_addr`=0. Every RAM word reads 0.
- R2: A data byte (`in_valid`=1, `in_is_cmd`=0) writes two RAM words in the cycle after it is presented. The word at `wr_addr` receives byte bits 7:4 and the word at `wr_addr`+1 receives bits 3:0. Within each nibble the most significant bit lands in word bit 0 (COM0) and the least significant bit lands in word bit 3. `wr_addr` then advances by 2, modulo 20.
- R3: Addressing wraps at the top. When `wr_addr` is 19, a data byte writes word 19 and word 0, and `wr_addr` becomes 1.
- R4: A command whose bits 6:5 are 00 loads `wr_addr` from bits 4:0 when that value is 19 or less. A value above 19 loads 0.
- R5: A command whose bits 6:3 are 1101 sets `clk_ext` from bit 0. If bit 1 is also 1, the command instead restores the R1 register values and `wr_addr`=0. In that case bit 0 is ignored and RAM contents are kept.
- R6: A command whose bits 6:5 are 01 loads `frame_sel` from bits 4:3 (0=80, 1=71, 2=64, 3=53 Hz), `frame_inv` from bit 2 (1 = frame inversion) and `drive_mode` from bits 1:0.
- R7: A command whose bits 6:5 are 10 and bit 2 is 0 loads `disp_en` from bit 3. The same pattern with bit 2 set to 1 is a prohibited bias request and changes nothing.
- R8: A command whose bits 6:3 are 1110 loads `blink_sel` from bits 1:0 (0=off, 1=0.5 Hz, 2=1 Hz, 3=2 Hz).
- R9: A command whose bits 6:2 are 11111 sets the override from bit 1 (all on) and bit 0 (all off). When both bits are 1, `pix_all_off`=1 and `pix_all_on`=0.
- R10: Bit 7 of a command is ignored. Unused command codes (bits 6:3 = 1100, and bits 6:2 = 11110) change nothing. Data bytes never change a control register. Nothing changes while `in_valid` is 0.
- R11: `rd_data` shows the RAM word at `rd_addr` combinationally. An `rd_addr` of 20 or more returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| in_valid | input | 1 | A byte is offered this cycle |
| in_is_cmd | input | 1 | 1 = byte is a command, 0 = display data |
| in_byte | input | 8 | Byte from the serial receiver |
| rd_addr | input | 5 | Scanner read address |
| rd_data | output | 4 | RAM word at `rd_addr`, bit n = COMn |
| wr_addr | output | 5 | Current RAM write pointer |
| clk_ext | output | 1 | 1 = external clock source selected |
| frame_sel | output | 2 | Frame-rate select |
| frame_inv | output | 1 | 1 = frame inversion, 0 = line inversion |
| drive_mode | output | 2 | Drive-strength mode |
| disp_en | output | 1 | Display enable |
| blink_sel | output | 2 | Blink-rate select |
| pix_all_on | output | 1 | All-pixel-on override in effect |
| pix_all_off | output | 1 | All-pixel-off override in effect |

## Verification
The embedded properties check the invariants that must hold on every cycle. The pointer never leaves the 0..19 range and steps by exactly two, modulo 20, on each data byte. An out-of-range address command always yields a zero pointer. Software reset always leaves the display off, the internal clock selected and the pointer at zero. Both override bits set always resolves to all-off. A mode command with the bias bit set leaves the display enable untouched, and data bytes leave the configuration alone.

Only the bench scenarios can show that a given nibble lands in the right word with the right bit order. They also show that wrap-around overwrites word 0, that RAM contents survive a software reset but not a power-on reset, and that the read port returns zero beyond the last segment.

// File: rtl/segram_ctrl.sv
module segram_ctrl #(
  parameter int unsigned SEGS = 20,
  localparam int unsigned COMS = 4,
  localparam int unsigned AW = 5
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            in_valid,
  input  logic            in_is_cmd,
  input  logic [7:0]      in_byte,
  input  logic [AW-1:0]   rd_addr,
  output logic [COMS-1:0] rd_data,
  output logic [AW-1:0]   wr_addr,
  output logic            clk_ext,
  output logic [1:0]      frame_sel,
  output logic            frame_inv,
  output logic [1:0]      drive_mode,
  output logic            disp_en,
  output logic [1:0]      blink_sel,
  output logic            pix_all_on,
  output logic            pix_all_off
);

  logic [COMS-1:0] ram [SEGS];
  logic [AW-1:0]   ptr_p1, ptr_p2;
  logic            pix_on_q;

  wire is_cmd  = in_valid & in_is_cmd;
  wire is_dat  = in_valid & ~in_is_cmd;
  wire op_addr = is_cmd & (in_byte[6:5] == 2'b00);
  wire op_disp = is_cmd & (in_byte[6:5] == 2'b01);
  wire op_mode = is_cmd & (in_byte[6:5] == 2'b10) & ~in_byte[2];
  wire op_ic   = is_cmd & (in_byte[6:3] == 4'b1101);
  wire op_blk  = is_cmd & (in_byte[6:3] == 4'b1110);
  wire op_pix  = is_cmd & (in_byte[6:2] == 5'b11111);
  wire soft_rst = op_ic & in_byte[1];

  function automatic logic [COMS-1:0] flip(input logic [COMS-1:0] n);
    for (int i = 0; i < COMS; i++) flip[i] = n[COMS-1-i];
  endfunction

  assign ptr_p1 = (wr_addr == AW'(SEGS-1)) ? '0 : wr_addr + 1'b1;
  assign ptr_p2 = (ptr_p1  == AW'(SEGS-1)) ? '0 : ptr_p1 + 1'b1;

  assign rd_data     = (int'(rd_addr) < SEGS) ? ram[rd_addr] : '0;
  assign pix_all_on  = pix_on_q & ~pix_all_off;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int s = 0; s < SEGS; s++) ram[s] <= '0;
    end else if (is_dat) begin
      ram[wr_addr] <= flip(in_byte[7:4]);
      ram[ptr_p1]  <= flip(in_byte[3:0]);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wr_addr    <= '0;
      clk_ext    <= 1'b0;
      frame_sel  <= 2'd0;
      frame_inv  <= 1'b0;
      drive_mode <= 2'b10;
      disp_en    <= 1'b0;
      blink_sel  <= 2'd0;
      pix_on_q   <= 1'b0;
      pix_all_off <= 1'b0;
    end else if (soft_rst) begin
      wr_addr    <= '0;
      clk_ext    <= 1'b0;
      frame_sel  <= 2'd0;
      frame_inv  <= 1'b0;
      drive_mode <= 2'b10;
      disp_en    <= 1'b0;
      blink_sel  <= 2'd0;
      pix_on_q   <= 1'b0;
      pix_all_off <= 1'b0;
    end else begin
      if (is_dat)  wr_addr <= ptr_p2;
      if (op_addr) wr_addr <= (int'(in_byte[4:0]) < SEGS) ? AW'(in_byte[4:0]) : '0;
      if (op_ic)   clk_ext <= in_byte[0];
      if (op_disp) begin
        frame_sel  <= in_byte[4:3];
        frame_inv  <= in_byte[2];
        drive_mode <= in_byte[1:0];
      end
      if (op_mode) disp_en   <= in_byte[3];
      if (op_blk)  blink_sel <= in_byte[1:0];
      if (op_pix) begin
        pix_on_q    <= in_byte[1];
        pix_all_off <= in_byte[0];
      end
    end
  end

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!por_n)
    int'(wr_addr) < SEGS);

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!por_n)
    (in_valid && !in_is_cmd) |=> int'(wr_addr) == (int'($past(wr_addr)) + 2) % SEGS);

  assert_addr_oor_R4: assert property (@(posedge clk) disable iff (!por_n)
    (in_valid && in_is_cmd && in_byte[6:5] == 2'b00 && int'(in_byte[4:0]) >= SEGS)
    |=> wr_addr == '0);

  assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!por_n)
    (in_valid && in_is_cmd && in_byte[6:3] == 4'b1101 && in_byte[1])
    |=> (!disp_en && !clk_ext && wr_addr == '0 && blink_sel == 2'd0));

  assert_bias_ignored_R7: assert property (@(posedge clk) disable iff (!por_n)
    (in_valid && in_is_cmd && in_byte[6:5] == 2'b10 && in_byte[2]) |=> $stable(disp_en));

  assert_pix_priority_R9: assert property (@(posedge clk) disable iff (!por_n)
    (in_valid && in_is_cmd && in_byte[6:2] == 5'b11111 && in_byte[1:0] == 2'b11)
    |=> (pix_all_off && !pix_all_on));

  assert_data_keeps_cfg_R10: assert property (@(posedge clk) disable iff (!por_n)
    (in_valid && !in_is_cmd) |=> ($stable(disp_en) && $stable(frame_sel) &&
      $stable(drive_mode) && $stable(blink_sel) && $stable(clk_ext) && $stable(pix_all_off)));

endmodule

// File: tb/segram_ctrl_tb_top.sv
module segram_ctrl_tb_top;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_is_cmd = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [4:0] rd_addr = 5'd0;
  logic [3:0] rd_data;
  logic [4:0] wr_addr;
  logic       clk_ext, frame_inv, disp_en, pix_all_on, pix_all_off;
  logic [1:0] frame_sel, drive_mode, blink_sel;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  segram_ctrl dut_i (
    .clk(clk), .por_n(por_n), .in_valid(in_valid), .in_is_cmd(in_is_cmd),
    .in_byte(in_byte), .rd_addr(rd_addr), .rd_data(rd_data), .wr_addr(wr_addr),
    .clk_ext(clk_ext), .frame_sel(frame_sel), .frame_inv(frame_inv),
    .drive_mode(drive_mode), .disp_en(disp_en), .blink_sel(blink_sel),
    .pix_all_on(pix_all_on), .pix_all_off(pix_all_off)
  );

  // cfg = {clk_ext, frame_sel, frame_inv, drive_mode, disp_en, blink_sel, all_on, all_off, wr_addr}
  wire [15:0] cfg = {clk_ext, frame_sel, frame_inv, drive_mode, disp_en,
                     blink_sel, pix_all_on, pix_all_off, wr_addr};
  localparam logic [15:0] CFG_DEF = {1'b0, 2'd0, 1'b0, 2'b10, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0};

  // entry = {req[3:0], is_cmd, byte[7:0], expected cfg[15:0]}
  localparam logic [28:0] VEC [16] = '{
    {4'd4,  1'b1, 8'h0A, 1'b0,2'd0,1'b0,2'd2,1'b0,2'd0,1'b0,1'b0,5'd10}, // R4 in range
    {4'd6,  1'b1, 8'hB7, 1'b0,2'd2,1'b1,2'd3,1'b0,2'd0,1'b0,1'b0,5'd10}, // R6, bit 7 ignored
    {4'd7,  1'b1, 8'h48, 1'b0,2'd2,1'b1,2'd3,1'b1,2'd0,1'b0,1'b0,5'd10}, // R7 on
    {4'd7,  1'b1, 8'h44, 1'b0,2'd2,1'b1,2'd3,1'b1,2'd0,1'b0,1'b0,5'd10}, // R7 bias bit: ignored
    {4'd8,  1'b1, 8'h72, 1'b0,2'd2,1'b1,2'd3,1'b1,2'd2,1'b0,1'b0,5'd10}, // R8
    {4'd9,  1'b1, 8'h7E, 1'b0,2'd2,1'b1,2'd3,1'b1,2'd2,1'b1,1'b0,5'd10}, // R9 all on
    {4'd9,  1'b1, 8'h7F, 1'b0,2'd2,1'b1,2'd3,1'b1,2'd2,1'b0,1'b1,5'd10}, // R9 both: off wins
    {4'd9,  1'b1, 8'hFC, 1'b0,2'd2,1'b1,2'd3,1'b1,2'd2,1'b0,1'b0,5'd10}, // R9 normal
    {4'd5,  1'b1, 8'h69, 1'b1,2'd2,1'b1,2'd3,1'b1,2'd2,1'b0,1'b0,5'd10}, // R5 external clock
    {4'd10, 1'b1, 8'h60, 1'b1,2'd2,1'b1,2'd3,1'b1,2'd2,1'b0,1'b0,5'd10}, // R10 unused code
    {4'd10, 1'b1, 8'h78, 1'b1,2'd2,1'b1,2'd3,1'b1,2'd2,1'b0,1'b0,5'd10}, // R10 unused code
    {4'd4,  1'b1, 8'h1F, 1'b1,2'd2,1'b1,2'd3,1'b1,2'd2,1'b0,1'b0,5'd0},  // R4 out of range
    {4'd2,  1'b0, 8'hA5, 1'b1,2'd2,1'b1,2'd3,1'b1,2'd2,1'b0,1'b0,5'd2},  // R2 data, R10 cfg kept
    {4'd4,  1'b1, 8'h13, 1'b1,2'd2,1'b1,2'd3,1'b1,2'd2,1'b0,1'b0,5'd19}, // R4 top address
    {4'd3,  1'b0, 8'h3C, 1'b1,2'd2,1'b1,2'd3,1'b1,2'd2,1'b0,1'b0,5'd1},  // R3 wrap
    {4'd5,  1'b1, 8'h6B, 1'b0,2'd0,1'b0,2'd2,1'b0,2'd0,1'b0,1'b0,5'd0}   // R5 soft reset, bit 0 ignored
  };

  function automatic logic [3:0] to_word(input logic [3:0] n);
    return {n[0], n[1], n[2], n[3]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic c, input logic [7:0] b, input logic v);
    @(negedge clk);
    in_valid = v; in_is_cmd = c; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_word(input int a, output logic [3:0] w);
    rd_addr = 5'(a);
    #1;
    w = rd_data;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] w;
    repeat (2) @(negedge clk);
    check("R1 cfg during reset", cfg, CFG_DEF);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 cfg after reset", cfg, CFG_DEF);
    read_word(5, w);
    check("R1 ram cleared", {12'd0, w}, 16'd0);

    for (int i = 0; i < 16; i++) begin
      send(VEC[i][24], VEC[i][23:16], 1'b1);
      check($sformatf("R%0d vector %0d", VEC[i][28:25], i), cfg, VEC[i][15:0]);
    end

    // R2: 0xA5 wrote word 0 (later overwritten) and word 1
    read_word(1, w);
    check("R2 low nibble word", {12'd0, w}, {12'd0, to_word(4'h5)});
    // R3: 0x3C at pointer 19 wrote word 19 and word 0
    read_word(19, w);
    check("R3 word 19", {12'd0, w}, {12'd0, to_word(4'h3)});
    read_word(0, w);
    check("R3 wrapped word 0", {12'd0, w}, {12'd0, to_word(4'hC)});
    // R5: soft reset kept RAM
    read_word(1, w);
    check("R5 ram kept", {12'd0, w}, 16'h000A);
    read_word(2, w);
    check("R2 untouched word", {12'd0, w}, 16'd0);
    // R11: out of range read
    read_word(20, w);
    check("R11 read addr 20", {12'd0, w}, 16'd0);
    read_word(31, w);
    check("R11 read addr 31", {12'd0, w}, 16'd0);

    // R10: nothing happens without in_valid
    send(1'b1, 8'h48, 1'b0);
    check("R10 invalid command", cfg, CFG_DEF);
    send(1'b0, 8'hFF, 1'b0);
    read_word(0, w);
    check("R10 invalid data", {12'd0, w}, {12'd0, to_word(4'hC)});

    // R2: fresh write at address 6, check both words and pointer
    send(1'b1, 8'h06, 1'b1);
    send(1'b0, 8'h81, 1'b1);
    check("R2 pointer step", {11'd0, wr_addr}, 16'd8);
    read_word(6, w);
    check("R2 high nibble order", {12'd0, w}, 16'h0001);
    read_word(7, w);
    check("R2 low nibble order", {12'd0, w}, 16'h0008);

    // R1: power-on reset clears RAM
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 cfg after second reset", cfg, CFG_DEF);
    read_word(19, w);
    check("R1 ram cleared word 19", {12'd0, w}, 16'd0);
    read_word(1, w);
    check("R1 ram cleared word 1", {12'd0, w}, 16'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule